// File: doc/BRIEF.md
# Status-Driven Bus Command Decoder

The decoder watches a 3-bit processor status bus, one sample per clock, and turns it into active-low command strobes for memory reads, memory writes, I/O reads, I/O writes and interrupt acknowledge. There is no separate start or stop strobe. A bus cycle begins when the status moves away from the all-ones idle code, and it ends when the status returns to that code.

When a cycle begins, the decoder captures the status code as the cycle type. For one clock it raises an address-latch-enable pulse. From the next clock onward it holds the matching command strobe low. The cycle closes on the first clock on which the idle code is sampled while the ready input is high. An idle code sampled while ready is low counts as a wait state, and the cycle goes on. While the bus is granted to another master, the status lines float to all ones, and the decoder treats this the same as idle.

A lock input keeps the busy flag high across cycle boundaries so that a bus arbiter outside the block can hold off other masters. A build option lets write strobes start together with the latch-enable pulse, for memories that need the extra setup.

Top module: `bus_cmd_decoder`

## Requirements
- R1: Status codes select commands as follows: 000 drives inta_n_o, 001 drives io_rd_n_o, 010 drives io_wr_n_o, 100 (code fetch) and 101 drive mem_rd_n_o, 110 drives mem_wr_n_o. Code 011 (halt) drives no strobe, and 111 is idle.
- R2: When a non-idle code is sampled with no cycle open, ale_o is high on the following clock for exactly one clock, and busy_o rises with it.
- R3: The command strobe for the cycle is low from the clock after the ale_o pulse until the clock on which the ending idle code is sampled. On that clock it returns high.
- R4: The cycle type is captured at the start. cyc_type_o shows it for the whole cycle and shows 111 when no cycle is open. A different non-idle code that appears mid-cycle changes neither cyc_type_o nor the strobe.
- R5: The idle code sampled with rdy_i low is a wait state. The cycle, its strobe and busy_o stay as they are.
- R6: The idle code sampled with rdy_i high ends the cycle. On the next clock all strobes are high and cyc_type_o is 111, and busy_o is low unless lock_i was high.
- R7: While lock_i is sampled high, busy_o is high on the next clock, even with no cycle open. lock_i never changes a strobe.
- R8: A synchronous active-high reset drives all strobes high, ale_o and busy_o low and cyc_type_o to 111, whatever the status input shows.
- R9: At most one command strobe is low at any time.
- R10: With EARLY_WR set, the mem_wr_n_o or io_wr_n_o strobe of a write cycle goes low on the same clock as ale_o. Read and acknowledge strobes keep the R3 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stat_i | input | STAT_W | Processor status code, 111 = idle |
| rdy_i | input | 1 | Ready; an idle code counts as the cycle end only while high |
| lock_i | input | 1 | Bus lock request, active high |
| ale_o | output | 1 | One-clock address latch enable pulse at cycle start |
| busy_o | output | 1 | Cycle open or lock held |
| cyc_type_o | output | STAT_W | Captured cycle type, 111 when idle |
| mem_rd_n_o | output | 1 | Memory read command, active low |
| mem_wr_n_o | output | 1 | Memory write command, active low |
| io_rd_n_o | output | 1 | I/O read command, active low |
| io_wr_n_o | output | 1 | I/O write command, active low |
| inta_n_o | output | 1 | Interrupt acknowledge command, active low |

## Verification
The bench runs every non-idle code with zero, one and two wait states, each with lock on and off, on a standard build and on an early-write build side by side. In every cycle it places a different non-idle code in the data phase. A decoder that re-reads the status mid-cycle would switch strobes there. A decoder that ends cycles on the idle code alone would drop the strobe in the first wait state. The bench also checks that halt leaves all strobes high, that lock holds busy across the idle gap and drops it once lock is released, and that a reset in the middle of a cycle clears an active strobe at once.

// File: rtl/bcd_pkg.sv
package bcd_pkg;

   localparam int ST_W = 3;

   typedef enum logic [ST_W-1:0] {
      ST_ACK   = 3'b000,
      ST_IORD  = 3'b001,
      ST_IOWR  = 3'b010,
      ST_HALT  = 3'b011,
      ST_FETCH = 3'b100,
      ST_MRD   = 3'b101,
      ST_MWR   = 3'b110,
      ST_IDLE  = 3'b111
   } stat_e;

   // command vector index
   localparam int NCMD  = 5;
   localparam int C_MRD = 0;
   localparam int C_MWR = 1;
   localparam int C_IRD = 2;
   localparam int C_IWR = 3;
   localparam int C_ACK = 4;

   localparam logic [NCMD-1:0] WR_MASK = (NCMD'(1) << C_MWR) | (NCMD'(1) << C_IWR);

   // one-hot active-high command selection for a status code
   function automatic logic [NCMD-1:0] cmd_sel(input logic [ST_W-1:0] code);
      logic [NCMD-1:0] sel;
      sel = '0;
      case (code)
         ST_ACK:           sel[C_ACK] = 1'b1;
         ST_IORD:          sel[C_IRD] = 1'b1;
         ST_IOWR:          sel[C_IWR] = 1'b1;
         ST_FETCH, ST_MRD: sel[C_MRD] = 1'b1;
         ST_MWR:           sel[C_MWR] = 1'b1;
         default:          sel = '0;
      endcase
      return sel;
   endfunction

endpackage

// File: rtl/bcd_frame.sv
module bcd_frame
   import bcd_pkg::*;
(
   input  logic            clk,
   input  logic            rst,
   input  logic [ST_W-1:0] stat_i,
   input  logic            rdy_i,
   output logic            start_o,
   output logic            finish_o,
   output logic            live_o,
   output logic            ale_o,
   output logic [ST_W-1:0] typ_o
);

   localparam logic [ST_W-1:0] IDLE = ST_IDLE;

   logic            live_q;
   logic            ale_q;
   logic [ST_W-1:0] typ_q;

   assign start_o  = !live_q && (stat_i != IDLE);
   assign finish_o =  live_q && (stat_i == IDLE) && rdy_i;

   always_ff @(posedge clk) begin
      if (rst) begin
         live_q <= 1'b0;
         ale_q  <= 1'b0;
         typ_q  <= IDLE;
      end else begin
         ale_q <= start_o;
         if (start_o) begin
            live_q <= 1'b1;
            typ_q  <= stat_i;
         end else if (finish_o) begin
            live_q <= 1'b0;
            typ_q  <= IDLE;
         end
      end
   end

   assign live_o = live_q;
   assign ale_o  = ale_q;
   assign typ_o  = typ_q;

endmodule

// File: rtl/bcd_cmd.sv
module bcd_cmd
   import bcd_pkg::*;
#(
   parameter bit EARLY_WR = 1'b0
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [ST_W-1:0] typ_i,
   input  logic [ST_W-1:0] stat_i,
   input  logic            start_i,
   input  logic            hold_i,
   output logic [NCMD-1:0] cmd_n_o
);

   logic [NCMD-1:0] sel_typ;
   logic [NCMD-1:0] sel_raw;

   assign sel_typ = cmd_sel(typ_i);
   assign sel_raw = cmd_sel(stat_i);

   for (genvar i = 0; i < NCMD; i++) begin : g_cmd
      if (EARLY_WR && WR_MASK[i]) begin : g_early
         always_ff @(posedge clk) begin
            if (rst) cmd_n_o[i] <= 1'b1;
            else     cmd_n_o[i] <= !((hold_i && sel_typ[i]) || (start_i && sel_raw[i]));
         end
      end else begin : g_std
         always_ff @(posedge clk) begin
            if (rst) cmd_n_o[i] <= 1'b1;
            else     cmd_n_o[i] <= !(hold_i && sel_typ[i]);
         end
      end
   end

endmodule

// File: rtl/bcd_busy.sv
module bcd_busy (
   input  logic clk,
   input  logic rst,
   input  logic live_nxt_i,
   input  logic lock_i,
   output logic busy_o
);

   always_ff @(posedge clk) begin
      if (rst) busy_o <= 1'b0;
      else     busy_o <= live_nxt_i || lock_i;
   end

endmodule

// File: rtl/bus_cmd_decoder.sv
module bus_cmd_decoder
   import bcd_pkg::*;
#(
   parameter int STAT_W   = 3,
   parameter bit EARLY_WR = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [STAT_W-1:0] stat_i,
   input  logic              rdy_i,
   input  logic              lock_i,
   output logic              ale_o,
   output logic              busy_o,
   output logic [STAT_W-1:0] cyc_type_o,
   output logic              mem_rd_n_o,
   output logic              mem_wr_n_o,
   output logic              io_rd_n_o,
   output logic              io_wr_n_o,
   output logic              inta_n_o
);

   if (STAT_W != ST_W) begin : g_bad_width
      $error("bus_cmd_decoder: STAT_W must equal the status code width");
   end

   logic            start;
   logic            finish;
   logic            live;
   logic            hold;
   logic [ST_W-1:0] typ;
   logic [NCMD-1:0] cmd_n;

   bcd_frame u_frame (
      .clk      (clk),
      .rst      (rst),
      .stat_i   (stat_i),
      .rdy_i    (rdy_i),
      .start_o  (start),
      .finish_o (finish),
      .live_o   (live),
      .ale_o    (ale_o),
      .typ_o    (typ)
   );

   // data phase continues into the next clock
   assign hold = live && !finish;

   bcd_cmd #(.EARLY_WR(EARLY_WR)) u_cmd (
      .clk     (clk),
      .rst     (rst),
      .typ_i   (typ),
      .stat_i  (stat_i),
      .start_i (start),
      .hold_i  (hold),
      .cmd_n_o (cmd_n)
   );

   bcd_busy u_busy (
      .clk        (clk),
      .rst        (rst),
      .live_nxt_i (start || hold),
      .lock_i     (lock_i),
      .busy_o     (busy_o)
   );

   assign cyc_type_o = typ;
   assign mem_rd_n_o = cmd_n[C_MRD];
   assign mem_wr_n_o = cmd_n[C_MWR];
   assign io_rd_n_o  = cmd_n[C_IRD];
   assign io_wr_n_o  = cmd_n[C_IWR];
   assign inta_n_o   = cmd_n[C_ACK];

endmodule

// File: rtl/bcd_chk.sv
module bcd_chk #(
   parameter int STAT_W = 3
) (
   input logic              clk,
   input logic              rst,
   input logic [STAT_W-1:0] stat_i,
   input logic              rdy_i,
   input logic              lock_i,
   input logic              ale_o,
   input logic              busy_o,
   input logic [STAT_W-1:0] cyc_type_o,
   input logic              mem_rd_n_o,
   input logic              mem_wr_n_o,
   input logic              io_rd_n_o,
   input logic              io_wr_n_o,
   input logic              inta_n_o
);

   localparam logic [STAT_W-1:0] IDLE = '1;

   logic [4:0] act;
   assign act = ~{inta_n_o, io_wr_n_o, io_rd_n_o, mem_wr_n_o, mem_rd_n_o};

   a_r1_mem_write_type: assert property (@(posedge clk) disable iff (rst)
      !mem_wr_n_o |-> cyc_type_o == 3'b110);

   a_r1_ack_type: assert property (@(posedge clk) disable iff (rst)
      !inta_n_o |-> cyc_type_o == 3'b000);

   a_r2_ale_single: assert property (@(posedge clk) disable iff (rst)
      ale_o |=> !ale_o);

   a_r2_ale_busy: assert property (@(posedge clk) disable iff (rst)
      ale_o |-> busy_o);

   a_r3_strobe_in_cycle: assert property (@(posedge clk) disable iff (rst)
      (act != 5'b0) |-> (busy_o && cyc_type_o != IDLE));

   a_r4_type_held: assert property (@(posedge clk) disable iff (rst)
      (cyc_type_o != IDLE) |=> (cyc_type_o == $past(cyc_type_o) || cyc_type_o == IDLE));

   a_r6_end_idle: assert property (@(posedge clk) disable iff (rst)
      (stat_i == IDLE && rdy_i && !lock_i) |=> (!busy_o && act == 5'b0));

   a_r7_lock_busy: assert property (@(posedge clk) disable iff (rst)
      lock_i |=> busy_o);

   a_r8_reset_clear: assert property (@(posedge clk)
      rst |=> (act == 5'b0 && !busy_o && !ale_o && cyc_type_o == IDLE));

   a_r9_single_strobe: assert property (@(posedge clk) disable iff (rst)
      $countones(act) <= 1);

endmodule

bind bus_cmd_decoder bcd_chk #(.STAT_W(STAT_W)) u_chk (.*);

// File: tb/bus_cmd_decoder_test.sv
module bus_cmd_decoder_test;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [2:0] stat = 3'b111;
   logic       rdy = 1'b1;
   logic       lock = 1'b0;

   logic       a0, b0, a1, b1;
   logic [2:0] t0, t1;
   logic       mr0, mw0, ir0, iw0, ia0;
   logic       mr1, mw1, ir1, iw1, ia1;

   int total = 0;
   int bad   = 0;

   always #2.5 clk = ~clk;

   bus_cmd_decoder uut (
      .clk(clk), .rst(rst), .stat_i(stat), .rdy_i(rdy), .lock_i(lock),
      .ale_o(a0), .busy_o(b0), .cyc_type_o(t0),
      .mem_rd_n_o(mr0), .mem_wr_n_o(mw0), .io_rd_n_o(ir0), .io_wr_n_o(iw0), .inta_n_o(ia0)
   );

   bus_cmd_decoder #(.EARLY_WR(1'b1)) uut_early (
      .clk(clk), .rst(rst), .stat_i(stat), .rdy_i(rdy), .lock_i(lock),
      .ale_o(a1), .busy_o(b1), .cyc_type_o(t1),
      .mem_rd_n_o(mr1), .mem_wr_n_o(mw1), .io_rd_n_o(ir1), .io_wr_n_o(iw1), .inta_n_o(ia1)
   );

   // R1 table, active-high mask {ack, io wr, io rd, mem wr, mem rd}
   function automatic logic [4:0] mask_of(input logic [2:0] c);
      case (c)
         3'b000:         return 5'b10000;
         3'b001:         return 5'b00100;
         3'b010:         return 5'b01000;
         3'b100, 3'b101: return 5'b00001;
         3'b110:         return 5'b00010;
         default:        return 5'b00000;
      endcase
   endfunction

   task automatic check(input string req, input logic [9:0] got, input logic [9:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%b expected=%b", req, got, exp);
      end
   endtask

   // drive one clock of inputs, sample 2 ns after the edge
   task automatic step(input logic [2:0] s, input logic r, input logic l);
      stat = s; rdy = r; lock = l;
      @(posedge clk);
      #2;
   endtask

   task automatic expect2(input string req, input logic a, input logic b, input logic [2:0] t,
                          input logic [4:0] m0, input logic [4:0] m1);
      logic [4:0] g0, g1;
      g0 = ~{ia0, iw0, ir0, mw0, mr0};
      g1 = ~{ia1, iw1, ir1, mw1, mr1};
      check({req, " std"},   {a0, b0, t0, g0}, {a, b, t, m0});
      check({req, " early"}, {a1, b1, t1, g1}, {a, b, t, m1});
      check("R9 one strobe", {8'd0, ($countones(g0) > 1), ($countones(g1) > 1)}, 10'd0);
   endtask

   task automatic bus_cycle(input logic [2:0] code, input int waits, input logic lk);
      logic [4:0] m;
      logic [2:0] other;
      m     = mask_of(code);
      other = (code == 3'b110) ? 3'b001 : (code ^ 3'b001);
      step(code, 1'b1, lk);
      // R2 pulse; R10 early write only on the early build
      expect2("R2/R10 start", 1'b1, 1'b1, code, 5'b0, m & 5'b01010);
      step(other, 1'b1, lk);
      expect2("R3/R4 data phase", 1'b0, 1'b1, code, m, m);
      for (int i = 0; i < waits; i++) begin
         step(3'b111, 1'b0, lk);
         expect2("R5 wait state", 1'b0, 1'b1, code, m, m);
      end
      step(3'b111, 1'b1, lk);
      expect2("R6/R7 end", 1'b0, lk, 3'b111, 5'b0, 5'b0);
      step(3'b111, 1'b1, 1'b0);
      expect2("R7 lock released", 1'b0, 1'b0, 3'b111, 5'b0, 5'b0);
   endtask

   initial begin
      // R8 reset with a non-idle status on the bus
      rst = 1'b1;
      step(3'b101, 1'b1, 1'b0);
      step(3'b101, 1'b1, 1'b0);
      expect2("R8 reset", 1'b0, 1'b0, 3'b111, 5'b0, 5'b0);
      rst = 1'b0;
      step(3'b111, 1'b1, 1'b0);
      expect2("R8 idle after reset", 1'b0, 1'b0, 3'b111, 5'b0, 5'b0);

      // idle with ready low: nothing starts
      step(3'b111, 1'b0, 1'b0);
      expect2("R5 idle ready low", 1'b0, 1'b0, 3'b111, 5'b0, 5'b0);

      // R1 sweep of all non-idle codes, waits and lock settings
      for (int c = 0; c < 7; c++)
         for (int w = 0; w < 3; w++)
            for (int l = 0; l < 2; l++)
               bus_cycle(3'(c), w, 1'(l));

      // R7 lock alone while idle
      step(3'b111, 1'b1, 1'b1);
      expect2("R7 idle lock", 1'b0, 1'b1, 3'b111, 5'b0, 5'b0);
      step(3'b111, 1'b1, 1'b0);
      expect2("R7 idle unlock", 1'b0, 1'b0, 3'b111, 5'b0, 5'b0);

      // R8 reset in the middle of a memory write
      step(3'b110, 1'b1, 1'b0);
      step(3'b110, 1'b1, 1'b0);
      expect2("R3 write active", 1'b0, 1'b1, 3'b110, 5'b00010, 5'b00010);
      rst = 1'b1;
      step(3'b110, 1'b1, 1'b0);
      expect2("R8 reset mid-cycle", 1'b0, 1'b0, 3'b111, 5'b0, 5'b0);
      rst = 1'b0;

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #1000000;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule